// File: doc/BRIEF.md
# Dual-Reference Clock Selector

This block decides which of two timing references, primary or secondary, a downstream digital PLL should follow. It watches a per-reference quality flag for each input and an operator preference. While the selected reference stays good, the selection holds. When the selected reference goes bad and the other one is good, the block fails over. When both are bad, it drops into holdover at once and keeps watching both flags. It leaves holdover for the first reference to become good again.

Once a reference is selected, the selection is sticky only if it is the operator's preferred one. A non-preferred selection always moves back to the preferred reference once that reference is good. The result is that the path out of holdover depends on which reference recovered first. Every automatic change of state is rate-limited by a dwell timer counted in ticks of a slow timing enable. Entering holdover is the one exception and is never delayed. A change of operator preference acts on the next clock when the newly preferred reference is good, and it restarts the dwell timer.

Top module: `dref_clock_selector`

## Requirements
- R1: After synchronous reset `holdover` is 1, `ref_sel` is 0 and `switch_pulse` is 0. The dwell timer starts expired, so the first valid reference can be taken on the first evaluation. Encoding: `ref_sel` 0 means primary and 1 means secondary; `cmd_sec` 0 prefers primary and 1 prefers secondary.
- R2: When out of holdover with the dwell timer expired, if the selected reference is invalid and the other is valid, `ref_sel` flips on the next clock.
- R3: When out of holdover, if both references are invalid, `holdover` rises on the next clock whatever the dwell timer state, and `ref_sel` keeps its value.
- R4: In holdover with the dwell timer expired, the block leaves holdover on the next clock for a valid reference. If both references are valid, it takes the preferred one.
- R5: When tracking the non-preferred reference with the dwell timer expired, the block moves to the preferred reference on the next clock once that reference is valid.
- R6: When tracking the preferred reference while it is valid and the preference is unchanged, the block stays on it, even while the other reference is valid.
- R7: After any change of `ref_sel` or `holdover`, no further automatic change except entry into holdover occurs until DWELL_TICKS assertions of `tick` have been counted.
- R8: A switch deferred by the dwell timer is taken on the clock after the timer expires, judged by the validity flags at that time.
- R9: When `cmd_sec` changes and the newly preferred reference is valid, the next clock selects it and clears `holdover`, regardless of the dwell timer.
- R10: Any change of `cmd_sec` restarts the dwell timer, even when the newly preferred reference is invalid.
- R11: `switch_pulse` is high for exactly one cycle, in the cycle in which `ref_sel` or `holdover` has just changed, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timing enable, one per dwell time unit |
| pri_ok | input | 1 | Primary reference is within specification |
| sec_ok | input | 1 | Secondary reference is within specification |
| cmd_sec | input | 1 | Operator preference: 0 primary, 1 secondary |
| ref_sel | output | 1 | Selected reference: 0 primary, 1 secondary |
| holdover | output | 1 | No reference is being tracked |
| switch_pulse | output | 1 | One-cycle pulse on each change of selection or holdover |

## Verification
A corrupted selection register shows up as a wrong `ref_sel` one clock after the bad decision, because the outputs come straight from state. A corrupted holdover register shows up as a wrong `holdover` in that same clock. A stuck or miscounted dwell counter has no effect until the next deferred switch. It then shows up as a switch that comes early or late by whole tick periods, so the bench holds the competing flag stable across each full dwell window. A broken preference-change detector misses the immediate selection on the clock after `cmd_sec` moves, or it fails to delay the next automatic switch.

// File: rtl/dref_sel_pkg.sv
package dref_sel_pkg;

   typedef enum logic {
      REF_PRI = 1'b0,
      REF_SEC = 1'b1
   } ref_id_t;

   typedef struct packed {
      ref_id_t sel;
      logic    hold;
   } sel_state_t;

   function automatic ref_id_t ref_other(input ref_id_t r);
      return (r == REF_PRI) ? REF_SEC : REF_PRI;
   endfunction

   function automatic logic ref_valid(input ref_id_t r, input logic p_ok, input logic s_ok);
      return (r == REF_PRI) ? p_ok : s_ok;
   endfunction

endpackage

// File: rtl/dref_dwell_timer.sv
module dref_dwell_timer #(
   parameter int unsigned DWELL_TICKS = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic restart,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(DWELL_TICKS + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_TICKS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= LOAD_VAL;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/dref_sel_decide.sv
module dref_sel_decide
   import dref_sel_pkg::*;
(
   input  sel_state_t cur,
   input  logic       pri_ok,
   input  logic       sec_ok,
   input  ref_id_t    want,
   input  logic       cmd_chg,
   input  logic       dwell_done,
   output sel_state_t nxt,
   output logic       changed
);
   logic cur_ok;
   logic alt_ok;
   logic want_ok;
   logic spare_ok;

   always_comb begin
      cur_ok   = ref_valid(cur.sel, pri_ok, sec_ok);
      alt_ok   = ref_valid(ref_other(cur.sel), pri_ok, sec_ok);
      want_ok  = ref_valid(want, pri_ok, sec_ok);
      spare_ok = ref_valid(ref_other(want), pri_ok, sec_ok);
      nxt      = cur;

      if (!cur.hold && !cur_ok && !alt_ok) begin
         // losing every reference never waits for the dwell timer
         nxt.hold = 1'b1;
      end else if (cmd_chg && want_ok) begin
         nxt.sel  = want;
         nxt.hold = 1'b0;
      end else if (!cmd_chg && dwell_done) begin
         if (cur.hold) begin
            if (want_ok) begin
               nxt.sel  = want;
               nxt.hold = 1'b0;
            end else if (spare_ok) begin
               nxt.sel  = ref_other(want);
               nxt.hold = 1'b0;
            end
         end else if (!cur_ok && alt_ok) begin
            nxt.sel = ref_other(cur.sel);
         end else if (cur_ok && (cur.sel != want) && want_ok) begin
            nxt.sel = want;
         end
      end
   end

   assign changed = (nxt != cur);

endmodule

// File: rtl/dref_clock_selector.sv
module dref_clock_selector
   import dref_sel_pkg::*;
#(
   parameter int unsigned DWELL_TICKS = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic pri_ok,
   input  logic sec_ok,
   input  logic cmd_sec,
   output logic ref_sel,
   output logic holdover,
   output logic switch_pulse
);
   if (DWELL_TICKS < 2) begin : g_bad_dwell
      $error("dref_clock_selector: DWELL_TICKS must be at least 2");
   end

   sel_state_t state_q;
   sel_state_t state_d;
   ref_id_t    want;
   logic       cmd_q;
   logic       cmd_chg;
   logic       changed;
   logic       dwell_done;
   logic       restart;
   logic       pulse_q;

   assign want    = ref_id_t'(cmd_sec);
   assign cmd_chg = (cmd_sec != cmd_q);
   assign restart = cmd_chg | changed;

   dref_sel_decide u_decide (
      .cur       (state_q),
      .pri_ok    (pri_ok),
      .sec_ok    (sec_ok),
      .want      (want),
      .cmd_chg   (cmd_chg),
      .dwell_done(dwell_done),
      .nxt       (state_d),
      .changed   (changed)
   );

   dref_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .restart(restart),
      .done   (dwell_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q.sel  <= REF_PRI;
         state_q.hold <= 1'b1;
         cmd_q        <= cmd_sec;
         pulse_q      <= 1'b0;
      end else begin
         state_q      <= state_d;
         cmd_q        <= cmd_sec;
         pulse_q      <= changed;
      end
   end

   assign ref_sel      = state_q.sel;
   assign holdover     = state_q.hold;
   assign switch_pulse = pulse_q;

endmodule

// File: rtl/dref_clock_selector_chk.sv
module dref_clock_selector_chk (
   input logic clk,
   input logic rst,
   input logic pri_ok,
   input logic sec_ok,
   input logic cmd_sec,
   input logic ref_sel,
   input logic holdover,
   input logic switch_pulse
);
   logic sel_ok;
   assign sel_ok = ref_sel ? sec_ok : pri_ok;

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (holdover && !ref_sel && !switch_pulse));

   a_r3_holdover_immediate: assert property (@(posedge clk) disable iff (rst)
      (!holdover && !pri_ok && !sec_ok) |=> (holdover && $stable(ref_sel)));

   a_r4_exit_to_valid: assert property (@(posedge clk) disable iff (rst)
      $fell(holdover) |-> (ref_sel ? $past(sec_ok) : $past(pri_ok)));

   a_r6_sticky_preferred: assert property (@(posedge clk) disable iff (rst)
      (!holdover && (ref_sel == cmd_sec) && sel_ok && (cmd_sec == $past(cmd_sec)))
      |=> (!holdover && $stable(ref_sel)));

   a_r9_cmd_takes_effect: assert property (@(posedge clk) disable iff (rst)
      ((cmd_sec != $past(cmd_sec)) && (cmd_sec ? sec_ok : pri_ok))
      |=> (!holdover && (ref_sel == $past(cmd_sec))));

   a_r11_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
      switch_pulse == ((ref_sel != $past(ref_sel)) || (holdover != $past(holdover))));

   a_r7_min_gap: assert property (@(posedge clk) disable iff (rst)
      switch_pulse ##1 (cmd_sec == $past(cmd_sec)) |=> (!switch_pulse || holdover));

endmodule

bind dref_clock_selector dref_clock_selector_chk chk_i (
   .clk         (clk),
   .rst         (rst),
   .pri_ok      (pri_ok),
   .sec_ok      (sec_ok),
   .cmd_sec     (cmd_sec),
   .ref_sel     (ref_sel),
   .holdover    (holdover),
   .switch_pulse(switch_pulse)
);

// File: tb/dref_clock_selector_tb_top.sv
`timescale 1ns/1ps
module dref_clock_selector_tb_top;
   localparam int DWELL = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic pri_ok = 1'b0;
   logic sec_ok = 1'b0;
   logic cmd_sec = 1'b0;
   logic ref_sel;
   logic holdover;
   logic switch_pulse;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int wd = 0;
   bit tick_en = 1'b1;
   string phase = "R1";

   // behavioural model state
   int m_sel, m_hold, m_pulse, m_cnt, m_cmd;

   always #4 clk = ~clk;

   dref_clock_selector #(.DWELL_TICKS(DWELL)) dut_i (
      .clk(clk), .rst(rst), .tick(tick), .pri_ok(pri_ok), .sec_ok(sec_ok),
      .cmd_sec(cmd_sec), .ref_sel(ref_sel), .holdover(holdover),
      .switch_pulse(switch_pulse)
   );

   function automatic int okf(int r);
      return (r == 0) ? int'(pri_ok) : int'(sec_ok);
   endfunction

   task automatic model_update();
      int ns, nh, chg, ev;
      if (rst) begin
         m_sel = 0; m_hold = 1; m_pulse = 0; m_cnt = 0; m_cmd = int'(cmd_sec);
         return;
      end
      ns = m_sel; nh = m_hold;
      chg = (int'(cmd_sec) != m_cmd);
      if (m_hold == 0 && okf(m_sel) == 0 && okf(1 - m_sel) == 0) nh = 1;
      else if (chg != 0 && okf(int'(cmd_sec)) != 0) begin ns = int'(cmd_sec); nh = 0; end
      else if (chg == 0 && m_cnt == 0) begin
         if (m_hold != 0) begin
            if (okf(int'(cmd_sec)) != 0) begin ns = int'(cmd_sec); nh = 0; end
            else if (okf(1 - int'(cmd_sec)) != 0) begin ns = 1 - int'(cmd_sec); nh = 0; end
         end else if (okf(m_sel) == 0 && okf(1 - m_sel) != 0) ns = 1 - m_sel;
         else if (okf(m_sel) != 0 && m_sel != int'(cmd_sec) && okf(int'(cmd_sec)) != 0)
            ns = int'(cmd_sec);
      end
      ev = (ns != m_sel) || (nh != m_hold);
      if (chg != 0 || ev != 0) m_cnt = DWELL;
      else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
      m_sel = ns; m_hold = nh; m_pulse = ev; m_cmd = int'(cmd_sec);
   endtask

   task automatic check(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         tick = tick_en && (cyc % 3 == 0);
         @(posedge clk);
         model_update();
         @(negedge clk);
         check(phase, int'(ref_sel), m_sel, "ref_sel vs model");
         check(phase, int'(holdover), m_hold, "holdover vs model");
         check(phase, int'(switch_pulse), m_pulse, "switch_pulse vs model");
         cyc++;
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 50000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset
      step(3);
      rst = 1'b0;
      step(1);
      check("R1", int'(holdover), 1, "holdover after reset");
      check("R1", int'(ref_sel), 0, "ref_sel after reset");
      check("R1", int'(switch_pulse), 0, "pulse after reset");
      step(5);

      // R4 leave holdover on first valid (secondary), timer expired
      phase = "R4";
      sec_ok = 1'b1;
      step(1);
      check("R4", int'(holdover), 0, "holdover exit");
      check("R4", int'(ref_sel), 1, "secondary taken first");
      check("R11", int'(switch_pulse), 1, "pulse on exit");
      phase = "R7";
      pri_ok = 1'b1;
      step(2);
      check("R7", int'(ref_sel), 1, "revert deferred by dwell");
      check("R11", int'(switch_pulse), 0, "pulse one cycle only");
      phase = "R5_R8";
      step(40);
      check("R5", int'(ref_sel), 0, "reverted to preferred primary");

      // R6 sticky on preferred
      phase = "R6";
      step(40);
      check("R6", int'(ref_sel), 0, "stays on primary");

      // R2 failover
      phase = "R2";
      pri_ok = 1'b0;
      step(1);
      check("R2", int'(ref_sel), 1, "failover to secondary");
      // R3 holdover immediately despite running timer
      phase = "R3";
      step(2);
      sec_ok = 1'b0;
      step(1);
      check("R3", int'(holdover), 1, "holdover immediate");
      check("R3", int'(ref_sel), 1, "ref_sel kept in holdover");
      step(40);
      // primary recovers first, then secondary: stay primary
      phase = "R6_recover";
      pri_ok = 1'b1;
      step(3);
      sec_ok = 1'b1;
      step(40);
      check("R6", int'(ref_sel), 0, "primary first stays");

      // R9 command change
      phase = "R9";
      cmd_sec = 1'b1;
      step(1);
      check("R9", int'(ref_sel), 1, "command takes effect");
      // R10 timer restarted: failover deferred
      phase = "R10";
      step(2);
      sec_ok = 1'b0;
      step(3);
      check("R10", int'(ref_sel), 1, "failover deferred after cmd change");
      phase = "R8";
      step(40);
      check("R8", int'(ref_sel), 0, "deferred failover taken");
      sec_ok = 1'b1;
      step(40);
      check("R5", int'(ref_sel), 1, "revert to preferred secondary");

      // R10 command change with invalid commanded reference
      phase = "R10b";
      pri_ok = 1'b0;
      step(1);
      cmd_sec = 1'b0;
      step(1);
      check("R10", int'(ref_sel), 1, "no move to invalid commanded");
      pri_ok = 1'b1;
      step(3);
      check("R10", int'(ref_sel), 1, "revert waits for restarted dwell");
      step(40);
      check("R5", int'(ref_sel), 0, "revert after dwell");

      // prefer secondary, holdover, secondary first: stays secondary
      phase = "R6_sec";
      cmd_sec = 1'b1;
      step(40);
      pri_ok = 1'b0; sec_ok = 1'b0;
      step(40);
      sec_ok = 1'b1;
      step(3);
      pri_ok = 1'b1;
      step(40);
      check("R6", int'(ref_sel), 1, "secondary first stays");

      // mixed stimulus, model compared every clock
      phase = "R2_R3_R4_R5_R7_R11_mix";
      for (int k = 0; k < 1500; k++) begin
         if ($urandom_range(15) == 0) pri_ok = ~pri_ok;
         if ($urandom_range(15) == 0) sec_ok = ~sec_ok;
         if ($urandom_range(60) == 0) cmd_sec = ~cmd_sec;
         step(1);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule